// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits on the receive path of an Ethernet MAC. It takes a byte-wide frame stream marked with valid, start-of-frame and end-of-frame, and with the end-of-frame byte it receives four status flags: FCS error, destination-address match, pause frame, and MAC control frame. It counts the frame length. At the last byte it decides whether the frame is forwarded or discarded. Every byte goes into a circular store first. A frame becomes visible to the reader only when its last byte has been accepted and the frame has passed the filter. A dropped frame therefore never reaches the output, not even in part.

The configuration inputs are static fields. One field sets accept-all (promiscuous) mode. Separate enables cover the removal of runts, FCS errors, address mismatches, pause frames and non-pause control frames. A 10-bit length limit is counted in 16-byte words, with reset value 0x280 (10240 bytes). When filtering is enabled (accept-all low), the address, FCS, pause and control rules apply. Accept-all switches those four rules off. It does not switch off the rules for decoding errors, runts, oversize frames or store capacity. Any frame longer than the limit also raises a one-cycle too-long pulse, whether or not the frame is forwarded.

The write side is a state machine with three states:
- W_IDLE waits for a start beat.
- W_RECV stores the bytes of the frame.
- W_SKIP discards the rest of a frame that found the store full.

The write-side transitions are:
- W_IDLE→W_RECV on a start beat that is not also an end beat.
- W_IDLE→W_SKIP or W_RECV→W_SKIP when there is no room for the beat.
- Any state→W_IDLE on an end beat.
- W_SKIP→W_RECV on a new start beat that finds room.

The read side has two states:
- R_HEAD: the next byte read starts a frame.
- R_BODY: the reader is inside a frame.

The read-side transitions are R_HEAD→R_BODY on reading a byte that is not a last byte, and R_BODY→R_HEAD on reading a last byte.

Top module: `rx_frame_filter`

## Requirements
- R1: A forwarded frame appears on the output byte for byte and in arrival order. The output start flag is set only on its first byte and the end flag only on its last byte. No byte of a frame is emitted before its last input byte has been accepted.
- R2: A frame of 8 bytes or fewer is a decoding error and is always dropped, in every configuration.
- R3: With runt removal on, a frame of 9 to 63 bytes is dropped even in accept-all mode. With runt removal off, such a frame passes the runt rule.
- R4: A frame whose byte count exceeds cfg_max_words×16 is always dropped, in accept-all mode too. A frame of exactly cfg_max_words×16 bytes passes this rule.
- R5: too_long is high for exactly one cycle, in the cycle after the end beat, for every frame longer than cfg_max_words×16 bytes, whether or not the frame is forwarded.
- R6: With filtering enabled and FCS removal on, a frame whose in_fcs_err is 1 on its end beat is dropped.
- R7: With filtering enabled and address removal on, a frame whose in_da_match is 0 on its end beat is dropped.
- R8: With filtering enabled, a pause frame (in_is_pause=1) is dropped when pause removal is on. A control frame that is not a pause frame (in_is_ctrl=1, in_is_pause=0) is dropped when control removal is on.
- R9: With cfg_accept_all=1, the FCS, address, pause and control rules have no effect.
- R10: Cycles with in_valid low are ignored. Beats outside a frame that carry no start flag are ignored, including their end flag.
- R11: A start beat arriving inside a frame abandons the partial frame. None of its bytes are emitted, and the new frame is handled normally.
- R12: A frame that meets a full store is dropped whole. With an empty store of DEPTH entries, a frame of DEPTH-1 bytes fits and a frame of DEPTH bytes does not.
- R13: During and right after reset, out_valid and too_long are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | DATA_W | Input byte |
| in_fcs_err | input | 1 | FCS error, sampled on the end beat |
| in_da_match | input | 1 | Destination address matched, sampled on the end beat |
| in_is_pause | input | 1 | Pause frame, sampled on the end beat |
| in_is_ctrl | input | 1 | MAC control frame, sampled on the end beat |
| cfg_accept_all | input | 1 | 1: accept-all mode; 0: filtering enabled |
| cfg_drop_runt | input | 1 | Remove 9..63-byte frames |
| cfg_drop_fcs | input | 1 | Remove frames with FCS error |
| cfg_drop_da | input | 1 | Remove frames without address match |
| cfg_drop_pause | input | 1 | Remove pause frames |
| cfg_drop_ctrl | input | 1 | Remove non-pause control frames |
| cfg_max_words | input | LIMIT_W | Length limit in 16-byte words |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |
| out_data | output | DATA_W | Output byte |
| too_long | output | 1 | One-cycle pulse per frame over the limit |

## Verification
The filter is driven with frames around each length edge: 1, 8, 9, 63, 64, the limit, the limit plus one, and the store capacity minus one and at capacity. These lengths separate the decoding-error, runt, oversize and capacity rules from each other. Each status flag is tried alone, first with its removal bit on and then with it off. The same flags are then repeated in accept-all mode, which shows which rules that mode suspends and which it keeps. Back-to-back frames, beats with valid gaps, stray beats outside a frame, and a start beat in the middle of a frame test ordering, ignored input and abandonment. The too-long pulses are counted against the frames that should raise them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_RECV,
        W_SKIP
    } wr_state_e;

    typedef enum logic {
        R_HEAD,
        R_BODY
    } rd_state_e;

    typedef struct packed {
        logic accept_all;
        logic drop_runt;
        logic drop_fcs;
        logic drop_da;
        logic drop_pause;
        logic drop_ctrl;
    } filt_cfg_t;

    localparam int unsigned DECODE_ERR_MAX = 8;
    localparam int unsigned RUNT_MAX       = 63;
    localparam int unsigned WORD_SHIFT     = 4;
    localparam int unsigned MAX_WORDS_RST  = 640;

endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned LIMIT_W = 10
) (
    input  logic [LEN_W-1:0]   byte_n,
    input  logic [LIMIT_W-1:0] max_words,
    input  filt_cfg_t          cfg,
    input  logic               fcs_err,
    input  logic               da_match,
    input  logic               is_pause,
    input  logic               is_ctrl,
    input  logic               overflowed,
    output logic               keep,
    output logic               over_limit
);
    logic [31:0] n32;
    logic [31:0] limit_bytes;
    logic        hard_drop;
    logic        soft_drop;

    always_comb begin
        n32         = 32'(byte_n);
        limit_bytes = 32'(max_words) << WORD_SHIFT;
        over_limit  = n32 > limit_bytes;

        // rules that accept-all mode leaves in force
        hard_drop = overflowed
                  || (n32 <= DECODE_ERR_MAX)
                  || (cfg.drop_runt && n32 <= RUNT_MAX)
                  || over_limit;

        // rules active only while filtering is enabled
        soft_drop = !cfg.accept_all && (
                       (cfg.drop_fcs   && fcs_err)
                    || (cfg.drop_da    && !da_match)
                    || (cfg.drop_pause && is_pause)
                    || (cfg.drop_ctrl  && is_ctrl && !is_pause));

        keep = !hard_drop && !soft_drop;
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_first,
    input  logic              wr_last,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_commit,
    output logic              room,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [DATA_W:0]  mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, cm_ptr, rd_ptr;
    logic [PTR_W-1:0] waddr, waddr_nxt;
    logic             have;
    logic             rd_last;
    rd_state_e        rd_st, rd_st_nxt;

    always_comb begin
        waddr     = wr_first ? cm_ptr : wr_ptr;
        waddr_nxt = waddr + 1'b1;
        room      = waddr_nxt != rd_ptr;
        have      = rd_ptr != cm_ptr;
        rd_last   = mem[rd_ptr][DATA_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= {wr_last, wr_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
        end else begin
            if (wr_en)     wr_ptr <= waddr_nxt;
            if (wr_commit) cm_ptr <= waddr_nxt;
        end
    end

    // read-side state register
    always_ff @(posedge clk) begin
        if (!rst_n) rd_st <= R_HEAD;
        else        rd_st <= rd_st_nxt;
    end

    always_comb begin
        rd_st_nxt = rd_st;
        unique case (rd_st)
            R_HEAD: if (have && !rd_last) rd_st_nxt = R_BODY;
            R_BODY: if (have && rd_last)  rd_st_nxt = R_HEAD;
            default: rd_st_nxt = R_HEAD;
        endcase
    end

    // read-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr    <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= have;
            out_sof   <= have && (rd_st == R_HEAD);
            out_eof   <= have && rd_last;
            if (have) begin
                out_data <= mem[rd_ptr][DATA_W-1:0];
                rd_ptr   <= rd_ptr + 1'b1;
            end
        end
    end

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> room);

    // R1
    commit_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (wr_en && wr_last));

    // R1
    sof_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid && out_eof)) |-> out_sof);

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned DEPTH   = 1024,
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned LIMIT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_fcs_err,
    input  logic               in_da_match,
    input  logic               in_is_pause,
    input  logic               in_is_ctrl,
    input  logic               cfg_accept_all,
    input  logic               cfg_drop_runt,
    input  logic               cfg_drop_fcs,
    input  logic               cfg_drop_da,
    input  logic               cfg_drop_pause,
    input  logic               cfg_drop_ctrl,
    input  logic [LIMIT_W-1:0] cfg_max_words,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_eof,
    output logic [DATA_W-1:0]  out_data,
    output logic               too_long
);
    wr_state_e        st, st_nxt;
    filt_cfg_t        cfg_s;
    logic [LEN_W-1:0] len_q, byte_n;
    logic             beat, skip, room, wr_en, last, commit;
    logic             keep, over_limit;

    assign cfg_s = '{accept_all: cfg_accept_all, drop_runt: cfg_drop_runt,
                     drop_fcs: cfg_drop_fcs, drop_da: cfg_drop_da,
                     drop_pause: cfg_drop_pause, drop_ctrl: cfg_drop_ctrl};

    always_comb begin
        beat   = in_valid && (in_sof || st != W_IDLE);
        byte_n = in_sof ? LEN_W'(1) : ((&len_q) ? len_q : len_q + 1'b1);
        skip   = (st == W_SKIP && !in_sof) || !room;
        wr_en  = beat && !skip;
        last   = beat && in_eof;
        commit = last && keep;
    end

    rxf_classify #(.LEN_W(LEN_W), .LIMIT_W(LIMIT_W)) u_classify (
        .byte_n     (byte_n),
        .max_words  (cfg_max_words),
        .cfg        (cfg_s),
        .fcs_err    (in_fcs_err),
        .da_match   (in_da_match),
        .is_pause   (in_is_pause),
        .is_ctrl    (in_is_ctrl),
        .overflowed (skip),
        .keep       (keep),
        .over_limit (over_limit)
    );

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_first  (in_sof),
        .wr_last   (in_eof),
        .wr_data   (in_data),
        .wr_commit (commit),
        .room      (room),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_data  (out_data)
    );

    // write-side state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            W_IDLE, W_RECV, W_SKIP: begin
                if (beat) begin
                    if (in_eof)    st_nxt = W_IDLE;
                    else if (skip) st_nxt = W_SKIP;
                    else           st_nxt = W_RECV;
                end
            end
            default: st_nxt = W_IDLE;
        endcase
    end

    // write-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            too_long <= 1'b0;
        end else begin
            if (beat) len_q <= byte_n;
            too_long <= last && over_limit;
        end
    end

    // R5
    too_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        too_long |-> $past(in_valid && in_eof));

    // R2
    decode_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && 32'(byte_n) <= DECODE_ERR_MAX) |-> !commit);

    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_IDLE && !in_sof) |-> !wr_en);

    // R4
    oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && 32'(byte_n) > (32'(cfg_max_words) << WORD_SHIFT)) |-> !commit);

endmodule

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_data = '0;
    logic       in_fcs_err = 0, in_da_match = 1, in_is_pause = 0, in_is_ctrl = 0;
    logic       c_all = 0, c_runt = 1, c_fcs = 1, c_da = 0, c_pause = 1, c_ctrl = 1;
    logic [9:0] c_max = 10'h280;
    logic       out_valid, out_sof, out_eof, too_long;
    logic [7:0] out_data;

    int nchk = 0, nfail = 0;
    int tl_cnt = 0, tl_exp = 0;
    int seed = 5;
    logic [9:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_filter #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .in_fcs_err(in_fcs_err),
        .in_da_match(in_da_match), .in_is_pause(in_is_pause),
        .in_is_ctrl(in_is_ctrl), .cfg_accept_all(c_all),
        .cfg_drop_runt(c_runt), .cfg_drop_fcs(c_fcs), .cfg_drop_da(c_da),
        .cfg_drop_pause(c_pause), .cfg_drop_ctrl(c_ctrl),
        .cfg_max_words(c_max), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_data(out_data), .too_long(too_long)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // output monitor: compares every output beat with the expected stream
    initial forever begin
        @(negedge clk);
        if (rst_n && too_long) tl_cnt++;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1 unexpected byte", int'({out_sof, out_eof, out_data}), 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({out_sof, out_eof, out_data} == e, "R1 output beat",
                    int'({out_sof, out_eof, out_data}), int'(e));
            end
        end
    end

    function automatic bit model_pass(int len, bit fcs, bit da, bit pz, bit ct);
        if (len > DEPTH - 1) return 0;
        if (len <= 8) return 0;
        if (len > int'(c_max) * 16) return 0;
        if (c_runt && len <= 63) return 0;
        if (!c_all) begin
            if (c_fcs && fcs) return 0;
            if (c_da && !da) return 0;
            if (c_pause && pz) return 0;
            if (c_ctrl && ct && !pz) return 0;
        end
        return 1;
    endfunction

    task automatic send_frame(int len, bit fcs, bit da, bit pz, bit ct, bit gaps);
        bit pass;
        pass = model_pass(len, fcs, da, pz, ct);
        if (len > int'(c_max) * 16) tl_exp++;
        if (pass)
            for (int i = 0; i < len; i++)
                exp_q.push_back({i == 0, i == len - 1, 8'(seed + i)});
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                in_valid = 0;
                @(negedge clk);
            end
            in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data = 8'(seed + i);
            in_fcs_err = fcs; in_da_match = da; in_is_pause = pz; in_is_ctrl = ct;
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        seed += 37;
    endtask

    task automatic settle(string req);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(tl_cnt == tl_exp, "R5 too_long count", tl_cnt, tl_exp);
        exp_q.delete();
    endtask

    task automatic cfg_default();
        c_all = 0; c_runt = 1; c_fcs = 1; c_da = 0; c_pause = 1; c_ctrl = 1;
        c_max = 10'h280;
    endtask

    task automatic t_reset();
        chk(out_valid == 0 && too_long == 0, "R13 in reset", int'({out_valid, too_long}), 0);
        @(negedge clk); rst_n = 1;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && too_long == 0, "R13 after reset", int'({out_valid, too_long}), 0);
    endtask

    task automatic t_basic();
        send_frame(64, 0, 1, 0, 0, 0);   settle("R1 single 64");
        send_frame(100, 0, 1, 0, 0, 0);
        send_frame(1518, 0, 1, 0, 0, 0);
        send_frame(77, 0, 1, 0, 0, 0);   settle("R1 back to back");
    endtask

    task automatic t_short();
        send_frame(1, 0, 1, 0, 0, 0);
        send_frame(8, 0, 1, 0, 0, 0);    settle("R2 decode error");
        send_frame(9, 0, 1, 0, 0, 0);
        send_frame(63, 0, 1, 0, 0, 0);
        send_frame(64, 0, 1, 0, 0, 0);   settle("R3 runt edges");
        c_runt = 0;
        send_frame(9, 0, 1, 0, 0, 0);
        send_frame(8, 0, 1, 0, 0, 0);    settle("R3 runt removal off");
        c_runt = 1; c_all = 1;
        send_frame(30, 0, 1, 0, 0, 0);
        send_frame(5, 0, 1, 0, 0, 0);    settle("R3 R2 in accept-all");
        cfg_default();
    endtask

    task automatic t_length();
        c_max = 10'd5;                    // 80 bytes
        send_frame(80, 0, 1, 0, 0, 0);
        send_frame(81, 0, 1, 0, 0, 0);
        send_frame(100, 1, 1, 0, 0, 0);  settle("R4 limit edges");
        c_all = 1;
        send_frame(81, 0, 1, 0, 0, 0);   settle("R4 accept-all oversize");
        cfg_default();
    endtask

    task automatic t_fcs();
        send_frame(70, 1, 1, 0, 0, 0);   settle("R6 fcs drop");
        c_fcs = 0;
        send_frame(70, 1, 1, 0, 0, 0);   settle("R6 fcs removal off");
        cfg_default();
    endtask

    task automatic t_da();
        c_da = 1;
        send_frame(70, 0, 0, 0, 0, 0);
        send_frame(71, 0, 1, 0, 0, 0);   settle("R7 address filter");
        cfg_default();
    endtask

    task automatic t_ctrl();
        send_frame(64, 0, 1, 1, 1, 0);
        send_frame(64, 0, 1, 0, 1, 0);   settle("R8 pause and control drop");
        c_pause = 0;
        send_frame(64, 0, 1, 1, 1, 0);
        send_frame(64, 0, 1, 0, 1, 0);   settle("R8 pause passes");
        c_pause = 1; c_ctrl = 0;
        send_frame(64, 0, 1, 0, 1, 0);
        send_frame(64, 0, 1, 1, 1, 0);   settle("R8 control passes");
        cfg_default();
    endtask

    task automatic t_promisc();
        c_all = 1; c_da = 1;
        send_frame(90, 1, 1, 0, 0, 0);
        send_frame(91, 0, 0, 0, 0, 0);
        send_frame(92, 0, 1, 1, 1, 0);
        send_frame(93, 0, 1, 0, 1, 0);   settle("R9 accept-all bypass");
        cfg_default();
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = 0; in_eof = (i == 2); in_data = 8'hA5;
        end
        @(negedge clk); in_valid = 0; in_eof = 0;
        send_frame(75, 0, 1, 0, 0, 1);   settle("R10 gaps and stray beats");
    endtask

    task automatic t_restart();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_eof = 0; in_data = 8'(i);
        end
        send_frame(70, 0, 1, 0, 0, 0);   settle("R11 abandoned partial");
    endtask

    task automatic t_capacity();
        send_frame(DEPTH - 1, 0, 1, 0, 0, 0); settle("R12 fits at DEPTH-1");
        send_frame(DEPTH, 0, 1, 0, 0, 0);
        send_frame(66, 0, 1, 0, 0, 0);       settle("R12 drop at DEPTH");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_short();
        t_length();
        t_fcs();
        t_da();
        t_ctrl();
        t_promisc();
        t_gaps();
        t_restart();
        t_capacity();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule